// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the device-side command engine of a word-wide parallel NOR-style flash, built as a synthesizable behavioural model around an inferable on-chip memory. A host writes command bytes over a simple synchronous bus. The engine switches what reads return between array contents, identifier codes and a status byte. It runs block erase, single-word program and per-block lock set and clear, and each of these keeps the device busy for a parameterised number of cycles. Faults are recorded in sticky error flags in the status byte.

Every modifying operation is a two-write sequence: a setup byte, then a confirm or data write. Once a setup byte is accepted, and again after every operation, reads return status until the host selects another read mode. While an operation runs, every read returns status and the engine ignores all writes.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the engine is in array-read mode, every block is unlocked, every word reads all ones, and the status byte reads 0x80.
- R2: A read strobe in one cycle gives `rvalid` high and valid `rdata` in the next cycle, and `rvalid` is low in any cycle that does not follow a read strobe.
- R3: After command byte 0x90, a read at word address 0 returns `MFR_ID`, a read at word address 1 returns `DEV_ID`, and a read at any other address returns 0.
- R4: Command byte 0xFF selects array-read mode from either identifier mode or status mode.
- R5: Command byte 0x70 selects status mode. The status byte sits in `rdata[7:0]` with all higher bits zero. Bit 7 is 1 when the engine is idle and 0 while it is busy. Bit 5 flags an erase fault, bit 4 a program fault, bit 3 low voltage and bit 1 a locked target. Bits 2 and 0 are always 0.
- R6: Error flags are sticky. Only command byte 0x50, written while idle, clears them, and it leaves the read mode unchanged.
- R7: Writing 0x20 and then 0xD0 to any address in a block sets every word of that block to all ones, leaves all other blocks unchanged, and keeps the engine busy for max(OP_CYC, 2^BLK_W) cycles.
- R8: Writing 0x40 and then a data word to an address stores old AND data at that address and keeps the engine busy for OP_CYC cycles.
- R9: Writing 0x60 and then 0x01 locks the addressed block. Writing 0x60 and then 0xD0 unlocks it. Each takes OP_CYC busy cycles.
- R10: An erase or program aimed at a locked block adds 0x02 together with 0x20 (erase) or 0x10 (program) to the status byte. The array is left unchanged and the engine does not go busy.
- R11: A setup byte of 0x20 or 0x60 followed by any byte other than its valid confirm sets 0x30 and aborts the operation without going busy.
- R12: If `vlow` is high when the second write of an operation arrives, the engine sets 0x08 together with 0x20 (erase), 0x10 (program) or 0x30 (lock). The array and the lock bits are left unchanged.
- R13: While busy, every read returns the status byte whatever the address or mode, all writes are ignored, and the error flags do not change.
- R14: After a setup byte is accepted, and after any operation ends or is rejected, reads return the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; command bytes in bits 7:0 |
| wr | input | 1 | Write strobe, one word per cycle |
| rd | input | 1 | Read strobe, one word per cycle |
| vlow | input | 1 | Supply-low indication, sampled when an operation would start |
| rdata | output | DATA_W | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after rd |

## Verification
The bench builds the engine with 16-bit words, a 64-word array, blocks of 8 words and OP_CYC of 4. With these values program and lock operations last 4 cycles and erase lasts 8, where the block size sets the erase length. Every busy cycle can therefore be read back-to-back and compared against an exact ready/busy expectation. With 8 blocks, the bench can lock one block while erasing and programming its neighbours, and can show that an erase changes only its own block.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  // command bytes
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLRERR = 8'h50;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_PROG   = 8'h40;
  localparam logic [7:0] CMD_LOCK   = 8'h60;
  localparam logic [7:0] CMD_OK     = 8'hD0;
  localparam logic [7:0] CMD_LSET   = 8'h01;

  // status flag masks (bits 6:1 are the sticky error field)
  localparam logic [7:0] FL_ERASE  = 8'h20;
  localparam logic [7:0] FL_PROG   = 8'h10;
  localparam logic [7:0] FL_VOLT   = 8'h08;
  localparam logic [7:0] FL_LOCKED = 8'h02;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_t;
  typedef enum logic [2:0] {S_IDLE, S_SET_ERS, S_SET_PGM, S_SET_LCK, S_BUSY} seq_t;
  typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_LSET, OP_LCLR} op_t;

endpackage

// File: rtl/nor_cmd_array.sv
module nor_cmd_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // power-up contents: erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 5,
  parameter int OP_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vlow,
  input  logic [DATA_W-1:0] mem_rq,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wa,
  output logic [DATA_W-1:0] mem_wd,
  output logic [ADDR_W-1:0] mem_ra,
  output logic              busy,
  output logic [7:0]        status,
  output rmode_t            rmode
);
  localparam int BA_W      = ADDR_W - BLK_W;
  localparam int NBLK      = 1 << BA_W;
  localparam int BLK_WORDS = 1 << BLK_W;
  localparam int PGM_CYC   = (OP_CYC < 2) ? 2 : OP_CYC;
  localparam int ERS_CYC   = (PGM_CYC > BLK_WORDS) ? PGM_CYC : BLK_WORDS;
  localparam int CNT_W     = $clog2(ERS_CYC + 1);

  seq_t              st_q;
  op_t               op_q;
  rmode_t            rmode_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [5:0]        err_q;     // status bits 6:1
  logic [NBLK-1:0]   lock_q;

  logic [7:0]        cmd;
  logic [BA_W-1:0]   blk, op_blk;
  logic [CNT_W-1:0]  cnt_last;

  assign cmd      = wdata[7:0];
  assign blk      = addr[ADDR_W-1:BLK_W];
  assign op_blk   = op_addr_q[ADDR_W-1:BLK_W];
  assign cnt_last = (op_q == OP_ERASE) ? CNT_W'(ERS_CYC - 1) : CNT_W'(PGM_CYC - 1);
  assign busy     = (st_q == S_BUSY);
  assign status   = {~busy, err_q, 1'b0};
  assign rmode    = rmode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      op_q      <= OP_PROG;
      rmode_q   <= RM_ARRAY;
      op_addr_q <= '0;
      op_data_q <= '0;
      cnt_q     <= '0;
      err_q     <= '0;
      lock_q    <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (wr) begin
          unique case (cmd)
            CMD_ARRAY:  rmode_q <= RM_ARRAY;
            CMD_IDENT:  rmode_q <= RM_IDENT;
            CMD_STATUS: rmode_q <= RM_STATUS;
            CMD_CLRERR: err_q   <= '0;
            CMD_ERASE:  begin st_q <= S_SET_ERS; rmode_q <= RM_STATUS; end
            CMD_PROG:   begin st_q <= S_SET_PGM; rmode_q <= RM_STATUS; end
            CMD_LOCK:   begin st_q <= S_SET_LCK; rmode_q <= RM_STATUS; end
            default: ;
          endcase
        end
        S_SET_ERS: if (wr) begin
          op_addr_q <= addr;
          op_q      <= OP_ERASE;
          cnt_q     <= '0;
          st_q      <= S_IDLE;
          if (cmd != CMD_OK)   err_q <= err_q | FL_ERASE[6:1] | FL_PROG[6:1];
          else if (vlow)       err_q <= err_q | FL_ERASE[6:1] | FL_VOLT[6:1];
          else if (lock_q[blk]) err_q <= err_q | FL_ERASE[6:1] | FL_LOCKED[6:1];
          else                 st_q  <= S_BUSY;
        end
        S_SET_PGM: if (wr) begin
          op_addr_q <= addr;
          op_data_q <= wdata;
          op_q      <= OP_PROG;
          cnt_q     <= '0;
          st_q      <= S_IDLE;
          if (vlow)             err_q <= err_q | FL_PROG[6:1] | FL_VOLT[6:1];
          else if (lock_q[blk]) err_q <= err_q | FL_PROG[6:1] | FL_LOCKED[6:1];
          else                  st_q  <= S_BUSY;
        end
        S_SET_LCK: if (wr) begin
          op_addr_q <= addr;
          op_q      <= (cmd == CMD_LSET) ? OP_LSET : OP_LCLR;
          cnt_q     <= '0;
          st_q      <= S_IDLE;
          if (cmd != CMD_LSET && cmd != CMD_OK)
            err_q <= err_q | FL_ERASE[6:1] | FL_PROG[6:1];
          else if (vlow)
            err_q <= err_q | FL_ERASE[6:1] | FL_PROG[6:1] | FL_VOLT[6:1];
          else
            st_q <= S_BUSY;
        end
        S_BUSY: begin
          if (cnt_q == cnt_last) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            if (op_q == OP_LSET) lock_q[op_blk] <= 1'b1;
            if (op_q == OP_LCLR) lock_q[op_blk] <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // array port: erase sweeps one word per cycle; program reads old word, then writes old AND data
  always_comb begin
    mem_ra = busy ? op_addr_q : addr;
    mem_we = 1'b0;
    mem_wa = op_addr_q;
    mem_wd = mem_rq & op_data_q;
    if (busy && op_q == OP_ERASE) begin
      mem_we = (cnt_q < CNT_W'(BLK_WORDS));
      mem_wa = {op_blk, cnt_q[BLK_W-1:0]};
      mem_wd = '1;
    end else if (busy && op_q == OP_PROG) begin
      mem_we = (cnt_q == cnt_last);
    end
  end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int          ADDR_W = 10,
  parameter int          DATA_W = 16,
  parameter int          BLK_W  = 5,
  parameter int          OP_CYC = 40,
  parameter logic [15:0] MFR_ID = 16'h00A7,
  parameter logic [15:0] DEV_ID = 16'h0C3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              vlow,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa, mem_ra;
  logic [DATA_W-1:0] mem_wd, mem_rq;
  logic              busy;
  logic [7:0]        status;
  rmode_t            rmode;

  logic              sel_arr_q;
  logic [DATA_W-1:0] info_q;

  nor_cmd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(mem_ra), .rq(mem_rq)
  );

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .OP_CYC(OP_CYC)) u_seq (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata), .vlow(vlow),
    .mem_rq(mem_rq), .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd),
    .mem_ra(mem_ra), .busy(busy), .status(status), .rmode(rmode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid    <= 1'b0;
      sel_arr_q <= 1'b0;
      info_q    <= '0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        sel_arr_q <= !busy && (rmode == RM_ARRAY);
        if (busy || rmode == RM_STATUS)
          info_q <= DATA_W'(status);
        else if (addr == '0)
          info_q <= DATA_W'(MFR_ID);
        else if (addr == ADDR_W'(1))
          info_q <= DATA_W'(DEV_ID);
        else
          info_q <= '0;
      end
    end
  end

  assign rdata = sel_arr_q ? mem_rq : info_q;

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic              rd,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              busy,
  input logic [7:0]        status
);
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid); // R2

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid); // R2

  AST_BUSY_READ_IS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (rd && busy) |=> (rdata == {{(DATA_W-8){1'b0}}, $past(status)})); // R13

  AST_ERR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(status[6:1])); // R13

  AST_ERR_ONLY_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    (($past(status[6:1]) & ~status[6:1]) != 6'd0) |->
      ($past(wr) && $past(wdata[7:0]) == 8'h50 && !$past(busy))); // R6

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr(wr), .rd(rd), .wdata(wdata),
  .rdata(rdata), .rvalid(rvalid), .busy(busy), .status(status)
);

// File: tb/nor_cmd_ctrl_bench.sv
module nor_cmd_ctrl_bench;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int BLK_W  = 3;
  localparam int OP_CYC = 4;
  localparam int ERS_CYC = 8;
  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DEV = 16'h0C3E;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              wr = 1'b0;
  logic              rd = 1'b0;
  logic              vlow = 1'b0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #5 clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .OP_CYC(OP_CYC),
                 .MFR_ID(MFR), .DEV_ID(DEV)) u_nor_cmd_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .vlow(vlow), .rdata(rdata), .rvalid(rvalid)
  );

  // driver tasks: called at a falling edge, return at the next one
  task automatic put(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic get(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops one expectation per returned word
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected rvalid, actual %h expected none", rdata);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    get(6'd0,  16'hFFFF, "R1 erased word");
    get(6'd63, 16'hFFFF, "R1 erased word");
    put(6'd0, 16'h0070);
    get(6'd5,  16'h0080, "R1 R5 reset status");

    // R3 / R4: identifier mode and return to array
    put(6'd0, 16'h0090);
    get(6'd0, MFR,      "R3 maker code");
    get(6'd1, DEV,      "R3 part code");
    get(6'd5, 16'h0000, "R3 other offset");
    put(6'd0, 16'h00FF);
    get(6'd2, 16'hFFFF, "R4 array from ident");

    // R8 / R14: program with exact busy window
    put(6'd9, 16'h0040);
    get(6'd9, 16'h0080, "R14 status after setup");
    put(6'd9, 16'h1234);
    for (int i = 0; i < OP_CYC; i++) get(6'd9, 16'h0000, "R8 busy cycle");
    get(6'd9, 16'h0080, "R8 ready after OP_CYC");
    put(6'd0, 16'h00FF);
    get(6'd9, 16'h1234, "R8 programmed word");
    put(6'd9, 16'h0040);
    put(6'd9, 16'hFF0F);
    idle_cyc(OP_CYC);
    put(6'd0, 16'h00FF);
    get(6'd9, 16'h1204, "R8 program ANDs");

    // R13: writes ignored while busy
    put(6'd10, 16'h0040);
    put(6'd10, 16'hA5A5);
    get(6'd10, 16'h0000, "R13 busy read");
    put(6'd0,  16'h00FF);
    get(6'd10, 16'h0000, "R13 busy read any addr");
    get(6'd3,  16'h0000, "R13 busy read");
    get(6'd10, 16'h0080, "R13 ready");
    get(6'd10, 16'h0080, "R13 0xFF during busy was ignored");
    put(6'd0,  16'h00FF);
    get(6'd10, 16'hA5A5, "R8 second program");

    // R7: erase block 1 leaves block 2 alone
    put(6'd16, 16'h0040);
    put(6'd16, 16'h00FF);
    idle_cyc(OP_CYC);
    put(6'd12, 16'h0020);
    put(6'd12, 16'h00D0);
    for (int i = 0; i < ERS_CYC; i++) get(6'd12, 16'h0000, "R7 erase busy cycle");
    get(6'd12, 16'h0080, "R7 ready after erase");
    put(6'd0, 16'h00FF);
    get(6'd9,  16'hFFFF, "R7 erased word");
    get(6'd10, 16'hFFFF, "R7 erased word");
    get(6'd15, 16'hFFFF, "R7 erased last word");
    get(6'd16, 16'h00FF, "R7 neighbour block kept");

    // R9 / R10: lock block 2, then try to modify it
    put(6'd20, 16'h0060);
    put(6'd20, 16'h0001);
    for (int i = 0; i < OP_CYC; i++) get(6'd20, 16'h0000, "R9 lock busy");
    get(6'd20, 16'h0080, "R9 lock ready");
    put(6'd17, 16'h0040);
    put(6'd17, 16'h0000);
    get(6'd17, 16'h0092, "R10 program on locked block");
    put(6'd16, 16'h0020);
    put(6'd16, 16'h00D0);
    get(6'd16, 16'h00B2, "R10 erase on locked block");
    put(6'd0, 16'h00FF);
    get(6'd16, 16'h00FF, "R10 locked word kept");
    get(6'd17, 16'hFFFF, "R10 locked word kept");
    put(6'd0, 16'h0070);
    get(6'd0, 16'h00B2, "R6 flags sticky");
    put(6'd0, 16'h0050);
    get(6'd0, 16'h0080, "R6 clear keeps status mode");
    put(6'd23, 16'h0060);
    put(6'd23, 16'h00D0);
    idle_cyc(OP_CYC);
    put(6'd17, 16'h0040);
    put(6'd17, 16'h0F0F);
    idle_cyc(OP_CYC);
    get(6'd17, 16'h0080, "R9 program after unlock ok");
    put(6'd0, 16'h00FF);
    get(6'd17, 16'h0F0F, "R9 unlocked block programs");

    // R11: bad confirm bytes
    put(6'd8, 16'h0020);
    put(6'd8, 16'h0033);
    get(6'd8, 16'h00B0, "R11 bad erase confirm");
    put(6'd0, 16'h00FF);
    get(6'd8, 16'hFFFF, "R11 array untouched");
    put(6'd0, 16'h0050);
    put(6'd16, 16'h0060);
    put(6'd16, 16'h0055);
    get(6'd16, 16'h00B0, "R11 bad lock confirm");
    put(6'd0, 16'h0050);
    put(6'd17, 16'h0040);
    put(6'd17, 16'h0000);
    idle_cyc(OP_CYC);
    put(6'd0, 16'h00FF);
    get(6'd17, 16'h0000, "R11 aborted lock left block open");

    // R12: low supply
    vlow = 1'b1;
    put(6'd24, 16'h0040);
    put(6'd24, 16'h0000);
    get(6'd24, 16'h0098, "R12 program low voltage");
    put(6'd0, 16'h0050);
    put(6'd24, 16'h0060);
    put(6'd24, 16'h0001);
    get(6'd24, 16'h00B8, "R12 lock low voltage");
    put(6'd0, 16'h0050);
    vlow = 1'b0;
    put(6'd0, 16'h00FF);
    get(6'd24, 16'hFFFF, "R12 array untouched");
    put(6'd25, 16'h0040);
    put(6'd25, 16'h1111);
    idle_cyc(OP_CYC);
    get(6'd25, 16'h0080, "R12 block not locked by failed lock");

    idle_cyc(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: actual %0d reads missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule